// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and End-of-Interrupt Unit

This block is the delivery side of a priority interrupt controller for one processor. A source router hands it requests. Each request carries a source index, a priority, a vector, a sense flag (edge or level) and the source's destination word. The unit keeps two bit sets with one bit per source. The first holds sources that are raised and waiting. The second holds sources the processor has taken and not yet finished. From these two sets it decides when to drive the processor's normal or critical interrupt line. It also stores the priority, vector, sense and routing of each accepted request in a small per-source table.

The processor interacts with the unit in four ways:
- It writes a task priority. This masks requests at or below that level.
- It writes a spurious vector.
- It issues an acknowledge read. This returns the vector of the best raised source, or the spurious vector when nothing valid is waiting.
- It writes an end-of-interrupt. This retires the most important in-service entry.

The router keeps each source's activity bit. The unit reports changes to it through a set strobe and a clear strobe. Each strobe carries a source index. The router returns the activity bits on a vector input, so the unit can notice level sources that went away before being acknowledged.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the task priority reads all ones (0xF), the spurious vector reads all ones (0xFF), both interrupt lines are low, ack_valid is low and both sets are empty.
- R2: A task-priority write keeps only the low 4 bits of cpu_wdata. A spurious-vector write keeps only the low 8 bits. Each value is visible on its output the cycle after the write.
- R3: A request whose priority is less than or equal to the current task priority has no effect: no set strobe, no change to the sets and no change to the interrupt lines.
- R4: A request for a source whose raised bit is already set is dropped. There is no set strobe, and the stored vector and priority of that source are unchanged.
- R5: An accepted request pulses act_set in the same cycle with act_set_src equal to the source index. It also sets that source's raised bit.
- R6: An accepted request drives an interrupt line high on the next cycle, with two exceptions. The line stays as it was if the request's priority is below the best raised priority. It also stays as it was if an in-service entry exists with priority greater than or equal to the request's.
- R7: The best entry of a set is the one with the strictly greatest priority. Among equal priorities, the lowest source index wins.
- R8: An acknowledge (ack_re) lowers both interrupt lines on the next cycle, unless a request raises a line in that same cycle. One cycle later ack_valid pulses with the result on ack_vec. An empty raised set returns the spurious vector.
- R9: If the best raised source is no longer active, or its priority no longer exceeds the task priority, the acknowledge returns the spurious vector. It also pulses act_clr for that source and removes it from the raised set.
- R10: Otherwise the acknowledge returns the source's stored vector and moves the source from the raised set to the in-service set. It pulses act_clr only for an edge source (sense flag 1).
- R11: An end-of-interrupt write removes the best in-service entry. If a raised entry remains and it outranks the best remaining in-service entry, or nothing remains in service, the line selected by that raised entry's routing goes high on the next cycle.
- R12: With critical routing enabled, a request whose destination word has bit (30 minus CPU_ID) set raises crit_out instead of irq_out. This holds for both the request itself and any later re-assertion after an end-of-interrupt.
- R13: An end-of-interrupt write in the same cycle as an acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request from the source router |
| req_src | input | IDX_W | Source index of the request |
| req_prio | input | PRIO_W | Priority of the request |
| req_vec | input | VEC_W | Vector of the request |
| req_edge | input | 1 | 1 = edge source, 0 = level source |
| req_route | input | DATA_W | Destination word; bit 30-CPU_ID selects critical delivery |
| src_active | input | NSRC | Activity bits held by the router |
| act_set | output | 1 | Set the activity bit of act_set_src (same cycle) |
| act_set_src | output | IDX_W | Source whose activity is set |
| act_clr | output | 1 | Clear the activity bit of act_clr_src (same cycle) |
| act_clr_src | output | IDX_W | Source whose activity is cleared |
| cpu_wdata | input | DATA_W | Write data for the processor strobes |
| tp_we | input | 1 | Task-priority write |
| spur_we | input | 1 | Spurious-vector write |
| eoi_we | input | 1 | End-of-interrupt write |
| ack_re | input | 1 | Acknowledge read |
| ack_valid | output | 1 | Acknowledge result valid, one cycle after ack_re |
| ack_vec | output | VEC_W | Acknowledge result |
| irq_out | output | 1 | Normal interrupt line |
| crit_out | output | 1 | Critical interrupt line |
| task_prio | output | PRIO_W | Current task priority |
| spur_vec | output | VEC_W | Current spurious vector |

## Verification
The bench goes after equal-priority ties, where a design that scanned from the top index would return the wrong vector. It covers two stale acknowledges: a level source that dropped out, and a task priority raised after the request. A design that skipped either check would hand out a dead vector instead of the spurious one. It also covers a re-request of an already raised source. A design that overwrote its table there would return the newer vector.

End-of-interrupt is tested with nested in-service entries. A design that retired the wrong entry, or ignored the rule that a line is raised when nothing remains in service, would hold the line at the wrong level. A combined acknowledge and end-of-interrupt cycle is also tested: a design that honoured both would later lose an in-service entry and raise a line that should stay low. Long stretches of mixed traffic are compared cycle by cycle against a behavioural model.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;

   // Outcome of an acknowledge read in the current cycle
   typedef enum logic [1:0] {
      ACK_NONE  = 2'd0,
      ACK_EMPTY = 2'd1,
      ACK_STALE = 2'd2,
      ACK_TAKE  = 2'd3
   } ack_kind_e;

endpackage

// File: rtl/irq_cpu_pick.sv
// Combinational best-entry search: strictly greatest priority, lowest index on ties.
module irq_cpu_pick #(
   parameter int NSRC   = 16,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 4
) (
   input  logic [NSRC-1:0]        member,
   input  logic [NSRC*PRIO_W-1:0] prio_flat,
   output logic                   found,
   output logic [IDX_W-1:0]       idx,
   output logic [PRIO_W-1:0]      prio
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      prio  = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (member[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > prio)) begin
            found = 1'b1;
            idx   = IDX_W'(i);
            prio  = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/irq_cpu_cfg.sv
// Task-priority and spurious-vector registers of one processor port.
module irq_cpu_cfg #(
   parameter int DATA_W = 32,
   parameter int PRIO_W = 4,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tp_we,
   input  logic              spur_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [PRIO_W-1:0] tp,
   output logic [VEC_W-1:0]  spur
);

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tp   <= '1;
         spur <= '1;
      end else begin
         if (tp_we)   tp   <= wdata[PRIO_W-1:0];
         if (spur_we) spur <= wdata[VEC_W-1:0];
      end
   end

   AST_TP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tp_we |=> tp == $past(wdata[PRIO_W-1:0])); // R2

   AST_SPUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      spur_we |=> spur == $past(wdata[VEC_W-1:0])); // R2

endmodule

// File: rtl/irq_cpu_srcmem.sv
// Per-source attribute table captured when a request is accepted.
module irq_cpu_srcmem #(
   parameter int NSRC   = 16,
   parameter int PRIO_W = 4,
   parameter int VEC_W  = 8,
   parameter int IDX_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       widx,
   input  logic [PRIO_W-1:0]      wprio,
   input  logic [VEC_W-1:0]       wvec,
   input  logic                   wedge,
   input  logic                   wcrit,
   output logic [NSRC*PRIO_W-1:0] prio_flat,
   output logic [NSRC*VEC_W-1:0]  vec_flat,
   output logic [NSRC-1:0]        edge_v,
   output logic [NSRC-1:0]        crit_v
);

   for (genvar g = 0; g < NSRC; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_flat[g*PRIO_W +: PRIO_W] <= '0;
            vec_flat[g*VEC_W +: VEC_W]    <= '0;
            edge_v[g]                     <= 1'b0;
            crit_v[g]                     <= 1'b0;
         end else if (we && widx == IDX_W'(g)) begin
            prio_flat[g*PRIO_W +: PRIO_W] <= wprio;
            vec_flat[g*VEC_W +: VEC_W]    <= wvec;
            edge_v[g]                     <= wedge;
            crit_v[g]                     <= wcrit;
         end
      end
   end

endmodule

// File: rtl/irq_cpu_port.sv
// One processor's delivery port: raised / in-service sets, acknowledge and EOI.
module irq_cpu_port
   import irq_cpu_pkg::*;
#(
   parameter int NSRC    = 16,
   parameter int PRIO_W  = 4,
   parameter int VEC_W   = 8,
   parameter int DATA_W  = 32,
   parameter int CPU_ID  = 0,
   parameter bit CRIT_EN = 1'b1,
   localparam int IDX_W  = $clog2(NSRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_src,
   input  logic [PRIO_W-1:0] req_prio,
   input  logic [VEC_W-1:0]  req_vec,
   input  logic              req_edge,
   input  logic [DATA_W-1:0] req_route,
   input  logic [NSRC-1:0]   src_active,
   output logic              act_set,
   output logic [IDX_W-1:0]  act_set_src,
   output logic              act_clr,
   output logic [IDX_W-1:0]  act_clr_src,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              tp_we,
   input  logic              spur_we,
   input  logic              eoi_we,
   input  logic              ack_re,
   output logic              ack_valid,
   output logic [VEC_W-1:0]  ack_vec,
   output logic              irq_out,
   output logic              crit_out,
   output logic [PRIO_W-1:0] task_prio,
   output logic [VEC_W-1:0]  spur_vec
);

   localparam int CRIT_BIT = 30 - CPU_ID;

   // ---------------- elaboration checks ----------------
   if (NSRC < 2) begin : g_bad_nsrc
      $error("irq_cpu_port: NSRC must be at least 2");
   end
   if (CPU_ID < 0 || CPU_ID > 30) begin : g_bad_cpu
      $error("irq_cpu_port: CPU_ID must lie in 0..30");
   end
   if (DATA_W < 31 || DATA_W < VEC_W || DATA_W < PRIO_W) begin : g_bad_data
      $error("irq_cpu_port: DATA_W too narrow");
   end

   // ---------------- state ----------------
   logic [NSRC-1:0] raised_q, raised_d;
   logic [NSRC-1:0] inserv_q, inserv_d;
   logic            irq_q, crit_q, irq_d, crit_d;
   logic            ackv_q;
   logic [VEC_W-1:0] ackvec_q, ackvec_d;

   logic [NSRC*PRIO_W-1:0] prio_flat;
   logic [NSRC*VEC_W-1:0]  vec_flat;
   logic [NSRC-1:0]        edge_v, crit_v;

   // ---------------- configuration registers ----------------
   irq_cpu_cfg #(.DATA_W(DATA_W), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .tp_we  (tp_we),
      .spur_we(spur_we),
      .wdata  (cpu_wdata),
      .tp     (task_prio),
      .spur   (spur_vec)
   );

   // ---------------- critical routing variant ----------------
   logic req_crit;
   logic unused_route;
   assign unused_route = ^req_route;

   if (CRIT_EN) begin : g_crit
      assign req_crit = req_route[CRIT_BIT];
   end else begin : g_nocrit
      assign req_crit = 1'b0;
   end

   // ---------------- best-entry searches ----------------
   logic             rh_found, sh_found, sr_found;
   logic [IDX_W-1:0] rh_idx, sh_idx, sr_idx;
   logic [PRIO_W-1:0] rh_prio, sh_prio, sr_prio;
   logic [NSRC-1:0]  inserv_rest;

   assign inserv_rest = sh_found ? (inserv_q & ~(NSRC'(1) << sh_idx)) : inserv_q;

   irq_cpu_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_raised (
      .member(raised_q), .prio_flat(prio_flat),
      .found(rh_found), .idx(rh_idx), .prio(rh_prio)
   );

   irq_cpu_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_serv (
      .member(inserv_q), .prio_flat(prio_flat),
      .found(sh_found), .idx(sh_idx), .prio(sh_prio)
   );

   irq_cpu_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_rest (
      .member(inserv_rest), .prio_flat(prio_flat),
      .found(sr_found), .idx(sr_idx), .prio(sr_prio)
   );

   logic unused_rest;
   assign unused_rest = ^sr_idx;

   // ---------------- request path ----------------
   logic req_ok, req_fire;

   assign req_ok   = req_valid && (req_prio > task_prio) && !raised_q[req_src];
   assign req_fire = req_ok
                   && !(rh_found && req_prio <  rh_prio)
                   && !(sh_found && req_prio <= sh_prio);

   irq_cpu_srcmem #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (req_ok),
      .widx     (req_src),
      .wprio    (req_prio),
      .wvec     (req_vec),
      .wedge    (req_edge),
      .wcrit    (req_crit),
      .prio_flat(prio_flat),
      .vec_flat (vec_flat),
      .edge_v   (edge_v),
      .crit_v   (crit_v)
   );

   // ---------------- acknowledge path ----------------
   ack_kind_e ack_kind;

   always_comb begin
      if (!ack_re)                                          ack_kind = ACK_NONE;
      else if (!rh_found)                                   ack_kind = ACK_EMPTY;
      else if (!src_active[rh_idx] || rh_prio <= task_prio) ack_kind = ACK_STALE;
      else                                                  ack_kind = ACK_TAKE;
   end

   assign ackvec_d = (ack_kind == ACK_TAKE) ? vec_flat[rh_idx*VEC_W +: VEC_W] : spur_vec;

   // ---------------- end-of-interrupt path ----------------
   logic eoi_go, eoi_fire;

   assign eoi_go   = eoi_we && !ack_re;
   assign eoi_fire = eoi_go && rh_found && (!sr_found || rh_prio > sr_prio);

   // ---------------- activity strobes ----------------
   assign act_set     = req_ok;
   assign act_set_src = req_src;
   assign act_clr     = (ack_kind == ACK_STALE) || (ack_kind == ACK_TAKE && edge_v[rh_idx]);
   assign act_clr_src = rh_idx;

   // ---------------- next state ----------------
   always_comb begin
      raised_d = raised_q;
      inserv_d = inserv_q;
      if (req_ok) raised_d[req_src] = 1'b1;
      if (ack_re && rh_found) raised_d[rh_idx] = 1'b0;
      if (ack_kind == ACK_TAKE) inserv_d[rh_idx] = 1'b1;
      if (eoi_go && sh_found) inserv_d[sh_idx] = 1'b0;
   end

   assign irq_d  = (req_fire && !req_crit) || (eoi_fire && !crit_v[rh_idx]) || (irq_q && !ack_re);
   assign crit_d = (req_fire &&  req_crit) || (eoi_fire &&  crit_v[rh_idx]) || (crit_q && !ack_re);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raised_q <= '0;
         inserv_q <= '0;
         irq_q    <= 1'b0;
         crit_q   <= 1'b0;
         ackv_q   <= 1'b0;
         ackvec_q <= '0;
      end else begin
         raised_q <= raised_d;
         inserv_q <= inserv_d;
         irq_q    <= irq_d;
         crit_q   <= crit_d;
         ackv_q   <= ack_re;
         if (ack_re) ackvec_q <= ackvec_d;
      end
   end

   assign irq_out   = irq_q;
   assign crit_out  = crit_q;
   assign ack_valid = ackv_q;
   assign ack_vec   = ackvec_q;

   // ---------------- assertions ----------------
   AST_LOW_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_prio <= task_prio) |-> !act_set); // R3

   AST_MISSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && raised_q[req_src] |-> !act_set); // R4

   AST_SET_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      act_set |=> raised_q[$past(act_set_src)]); // R5

   AST_PICK_MEMBER: assert property (@(posedge clk) disable iff (!rst_n)
      rh_found |-> raised_q[rh_idx]); // R7

   AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_re && !req_valid |=> !irq_out && !crit_out); // R8

   AST_ACK_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      ack_re |=> ack_valid); // R8

   AST_CLR_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      act_clr |-> ack_re); // R9

   AST_TAKE_SERV: assert property (@(posedge clk) disable iff (!rst_n)
      ack_re && act_clr && src_active[act_clr_src] && !edge_v[act_clr_src] |=> ack_vec == $past(spur_vec)); // R9

   AST_EOI_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_we && !ack_re && sh_found |=> !inserv_q[$past(sh_idx)]); // R11

endmodule

// File: tb/sim_irq_cpu_port.sv
module sim_irq_cpu_port;

   localparam int NSRC = 16, PRIO_W = 4, VEC_W = 8, DATA_W = 32, IDX_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              req_valid = 1'b0;
   logic [IDX_W-1:0]  req_src = '0;
   logic [PRIO_W-1:0] req_prio = '0;
   logic [VEC_W-1:0]  req_vec = '0;
   logic              req_edge = 1'b0;
   logic [DATA_W-1:0] req_route = '0;
   logic [NSRC-1:0]   src_active = '0;
   logic              act_set, act_clr;
   logic [IDX_W-1:0]  act_set_src, act_clr_src;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic tp_we = 1'b0, spur_we = 1'b0, eoi_we = 1'b0, ack_re = 1'b0;
   logic              ack_valid, irq_out, crit_out;
   logic [VEC_W-1:0]  ack_vec, spur_vec;
   logic [PRIO_W-1:0] task_prio;

   irq_cpu_port #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .DATA_W(DATA_W),
                  .CPU_ID(0), .CRIT_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio), .req_vec(req_vec),
      .req_edge(req_edge), .req_route(req_route), .src_active(src_active),
      .act_set(act_set), .act_set_src(act_set_src), .act_clr(act_clr), .act_clr_src(act_clr_src),
      .cpu_wdata(cpu_wdata), .tp_we(tp_we), .spur_we(spur_we), .eoi_we(eoi_we), .ack_re(ack_re),
      .ack_valid(ack_valid), .ack_vec(ack_vec), .irq_out(irq_out), .crit_out(crit_out),
      .task_prio(task_prio), .spur_vec(spur_vec)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_tp, m_spur, m_ackvec;
   logic [NSRC-1:0] m_raised, m_inserv, m_act, m_edge, m_crit;
   int m_prio[NSRC];
   int m_vec[NSRC];
   bit m_irq, m_cr, m_ackv;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int best(input logic [NSRC-1:0] s, input int skip);
      int b = -1;
      for (int i = 0; i < NSRC; i++)
         if (s[i] && i != skip && (b < 0 || m_prio[i] > m_prio[b])) b = i;
      return b;
   endfunction

   // one clock: compare, model the edge, release strobes at the falling edge
   task automatic cyc();
      int rh, sh, sr, cs, rv, rs, rp;
      bit ok, fire, crt, take, clr, eo, eof, ni, nc;
      #2;
      rh = best(m_raised, -1);
      sh = best(m_inserv, -1);
      sr = best(m_inserv, sh);
      rs = int'(req_src);
      rp = int'(req_prio);
      ok   = req_valid && rp > m_tp && !m_raised[rs];
      fire = ok && !(rh >= 0 && rp < m_prio[rh]) && !(sh >= 0 && rp <= m_prio[sh]);
      crt  = req_route[30];
      take = 0; clr = 0; cs = 0; rv = m_spur;
      if (ack_re && rh >= 0) begin
         if (!m_act[rh] || m_prio[rh] <= m_tp) begin
            clr = 1; cs = rh;
         end else begin
            take = 1; rv = m_vec[rh];
            if (m_edge[rh]) begin clr = 1; cs = rh; end
         end
      end
      eo  = eoi_we && !ack_re;
      eof = eo && rh >= 0 && (sr < 0 || m_prio[rh] > m_prio[sr]);
      chk("R6 irq_out", int'(irq_out), int'(m_irq));
      chk("R12 crit_out", int'(crit_out), int'(m_cr));
      chk("R2 task_prio", int'(task_prio), m_tp);
      chk("R2 spur_vec", int'(spur_vec), m_spur);
      chk("R8 ack_valid", int'(ack_valid), int'(m_ackv));
      if (m_ackv) chk("R10 ack_vec", int'(ack_vec), m_ackvec);
      chk("R5 act_set", int'(act_set), int'(ok));
      if (ok) chk("R5 act_set_src", int'(act_set_src), rs);
      chk("R9 act_clr", int'(act_clr), int'(clr));
      if (clr) chk("R9 act_clr_src", int'(act_clr_src), cs);
      ni = (fire && !crt) || (eof && !m_crit[rh]) || (m_irq && !ack_re);
      nc = (fire &&  crt) || (eof &&  m_crit[rh]) || (m_cr  && !ack_re);
      @(posedge clk);
      if (ok) begin
         m_raised[rs] = 1; m_prio[rs] = rp; m_vec[rs] = int'(req_vec);
         m_edge[rs] = req_edge; m_crit[rs] = crt; m_act[rs] = 1;
      end
      if (ack_re && rh >= 0) begin
         m_raised[rh] = 0;
         if (take) m_inserv[rh] = 1;
      end
      if (clr) m_act[cs] = 0;
      if (eo && sh >= 0) m_inserv[sh] = 0;
      m_ackv = ack_re;
      if (ack_re) m_ackvec = rv;
      if (tp_we)   m_tp   = int'(cpu_wdata & 32'hF);
      if (spur_we) m_spur = int'(cpu_wdata & 32'hFF);
      m_irq = ni; m_cr = nc;
      @(negedge clk);
      src_active = m_act;
      req_valid = 0; ack_re = 0; eoi_we = 0; tp_we = 0; spur_we = 0; req_route = '0;
   endtask

   task automatic req(input int s, input int p, input int v, input bit e, input bit c);
      req_valid = 1; req_src = IDX_W'(s); req_prio = PRIO_W'(p); req_vec = VEC_W'(v);
      req_edge = e; req_route = c ? 32'h4000_0000 : 32'h0000_0001;
      cyc();
   endtask

   task automatic do_ack();  ack_re = 1; cyc(); endtask
   task automatic do_eoi();  eoi_we = 1; cyc(); endtask
   task automatic wtp(input int v);   tp_we = 1;   cpu_wdata = DATA_W'(v); cyc(); endtask
   task automatic wspur(input int v); spur_we = 1; cpu_wdata = DATA_W'(v); cyc(); endtask
   task automatic drop(input int s); m_act[s] = 0; src_active = m_act; endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] lf;
      m_tp = 15; m_spur = 255; m_ackvec = 0;
      m_raised = '0; m_inserv = '0; m_act = '0; m_edge = '0; m_crit = '0;
      m_irq = 0; m_cr = 0; m_ackv = 0;
      for (int i = 0; i < NSRC; i++) begin m_prio[i] = 0; m_vec[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq_out", int'(irq_out), 0);
      chk("R1 crit_out", int'(crit_out), 0);
      chk("R1 task_prio", int'(task_prio), 15);
      chk("R1 spur_vec", int'(spur_vec), 255);
      chk("R1 ack_valid", int'(ack_valid), 0);
      rst_n = 1'b1;
      cyc();
      do_ack();
      chk("R1 empty ack", int'(ack_vec), 255);

      wtp(32'h35);
      wspur(32'h1AB);
      chk("R2 tp low bits", int'(task_prio), 5);
      chk("R2 spur low bits", int'(spur_vec), 'hAB);

      req(3, 5, 'h33, 1, 0);
      chk("R3 at task prio", int'(irq_out), 0);
      req(3, 9, 'h33, 1, 0);
      chk("R6 raise", int'(irq_out), 1);
      req(7, 7, 'h77, 0, 0);
      req(2, 9, 'h22, 1, 0);
      do_ack();
      chk("R7 tie lowest index", int'(ack_vec), 'h22);
      chk("R8 line lowered", int'(irq_out), 0);
      do_ack();
      chk("R10 vector", int'(ack_vec), 'h33);
      do_eoi();
      chk("R11 no reassert", int'(irq_out), 0);
      do_eoi();
      chk("R11 reassert empty service", int'(irq_out), 1);
      drop(7);
      do_ack();
      chk("R9 inactive stale", int'(ack_vec), 'hAB);
      do_ack();
      chk("R8 empty spurious", int'(ack_vec), 'hAB);

      req(5, 8, 'h55, 0, 0);
      req(5, 10, 'h5A, 0, 0);
      do_ack();
      chk("R4 missed keeps old vector", int'(ack_vec), 'h55);
      do_eoi();
      drop(5);

      req(6, 8, 'h66, 0, 0);
      wtp(9);
      do_ack();
      chk("R9 priority stale", int'(ack_vec), 'hAB);
      wtp(2);

      req(4, 6, 'h44, 1, 1);
      chk("R12 critical high", int'(crit_out), 1);
      chk("R12 normal low", int'(irq_out), 0);
      do_ack();
      chk("R12 critical vector", int'(ack_vec), 'h44);
      chk("R12 critical lowered", int'(crit_out), 0);
      do_eoi();

      req(9, 5, 'h99, 1, 0);
      do_ack();
      req(10, 12, 'hAA, 1, 0);
      ack_re = 1; eoi_we = 1; cyc();
      chk("R13 ack wins", int'(ack_vec), 'hAA);
      req(11, 11, 'hBB, 1, 0);
      chk("R6 hidden by service", int'(irq_out), 0);
      do_eoi();
      chk("R11 outranks remainder", int'(irq_out), 1);
      do_ack();
      do_eoi();
      req(12, 3, 'hCC, 1, 0);
      chk("R13 eoi was ignored", int'(irq_out), 0);
      do_eoi();
      chk("R11 reassert after last", int'(irq_out), 1);
      do_ack();
      chk("R10 low prio vector", int'(ack_vec), 'hCC);
      do_eoi();

      // mixed traffic against the model
      lf = 32'hACE1_2468;
      for (int k = 0; k < 3000; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         case (lf[22:20])
            3'd0, 3'd1, 3'd2: begin
               if (!m_act[lf[3:0]]) begin
                  req_valid = 1; req_src = lf[3:0]; req_prio = lf[7:4]; req_vec = lf[15:8];
                  req_edge = lf[16]; req_route = (lf[17] & lf[18]) ? 32'h4000_0000 : 32'h0;
               end
               if (lf[19]) ack_re = 1;
               cyc();
            end
            3'd3: do_ack();
            3'd4: begin eoi_we = 1; if (lf[9] & lf[10]) ack_re = 1; cyc(); end
            3'd5: begin tp_we = 1; cpu_wdata = {28'h0, 1'b0, lf[2:0]}; cyc(); end
            3'd6: begin if (!m_edge[lf[11:8]]) drop(int'(lf[11:8])); cyc(); end
            default: cyc();
         endcase
      end
      finish_run();
   end

endmodule